// File: doc/BRIEF.md
# Manual-Trigger Word Boundary Aligner

This block sits behind a deserializer whose parallel words carry an unknown bit rotation. It keeps the previous accepted word and joins it with the word now arriving, so that it can look at every one of the W possible word boundaries at once. A programmable alignment pattern is compared at each candidate boundary. When a search is armed and the pattern turns up, the block captures that boundary and from then on emits words cut out of the stream at that boundary.

The alignment is one-shot. A rising edge on the user enable arms one search. The boundary it finds stays fixed however the stream changes afterwards, until the enable rises again. When the parameter for automatic locking is set, which is the default at the 20-bit width, one search is also armed by reset. The pattern length can be 7 or 10 bits, or 20 bits when the width allows it. A detect flag shows each word in which the pattern sits exactly on the locked boundary.

Top module: `word_aligner`

## Requirements
- R1: While `rst` is sampled high, and on the clock after it, `sync`, `pat_det` and `word_valid` are 0 and `word_out` is 0. The locked offset resets to 0.
- R2: With `AUTO_LOCK` set (the default when W >= 20), reset arms a search with no enable edge. The first valid word whose window holds the pattern locks the boundary.
- R3: A rising edge on `align_en` (high now, low on the previous clock) clears `sync` on the next clock and arms a search. The word presented in that same cycle is not searched.
- R4: The search window is {`rx_word`, previous valid word}, with bit 0 of the previous word as window bit 0. Offset k means window bits k to k+W-1. When an armed search finds the pattern in a valid word, `sync` is 1 on the next clock and `word_out` is that word's window at offset k.
- R5: When the pattern matches at several offsets in one window, the lowest offset is locked.
- R6: Once locked, the offset does not change and `sync` stays 1 until the next rising edge of `align_en`. Patterns at other offsets, and holding `align_en` high, have no effect.
- R7: `pat_det` is 1 for one clock after a valid word whose window holds the pattern at the locked offset while locked. Otherwise it is 0.
- R8: `pat_len_sel` picks the pattern length: 0 gives 7 bits, 1 gives 10 bits, and 2 gives 20 bits (10 bits when W < 20). Code 3 gives 10 bits. Only `pat_value` bits below the length are compared.
- R9: `word_valid` equals `rx_valid` delayed by one clock. `word_out` changes only after a valid word.
- R10: A cycle with `rx_valid` low neither searches nor replaces the stored previous word. A pattern split across two valid words that have invalid cycles between them is still found.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_word | input | W | Raw parallel word from the deserializer |
| rx_valid | input | 1 | `rx_word` carries a word this cycle |
| align_en | input | 1 | User alignment request; its rising edge arms a search |
| pat_value | input | W | Alignment pattern, low bits significant |
| pat_len_sel | input | 2 | Pattern length code |
| word_out | output | W | Word realigned to the locked boundary |
| word_valid | output | 1 | `word_out` updated this cycle |
| sync | output | 1 | Boundary locked |
| pat_det | output | 1 | Pattern seen at the locked boundary |

## Verification
Every result is registered once. The aligned word, `word_valid` and `pat_det` for a word appear on the clock after the edge that samples it. A lock appears on the clock after the word that completes the pattern, and the cleared `sync` appears on the clock after the enable's rising edge. The bench drives each input set on a falling edge and lets exactly one rising edge pass. It then compares all four outputs on the next falling edge, against a bench model updated at that same edge. Directed pairs of words place the pattern at known offsets, so that the expected aligned word is a plain slice of the pair.

// File: rtl/wal_pkg.sv
package wal_pkg;

    // Pattern length codes on pat_len_sel
    typedef enum logic [1:0] {
        PLEN_SHORT = 2'd0,
        PLEN_MID   = 2'd1,
        PLEN_FULL  = 2'd2,
        PLEN_SPARE = 2'd3
    } plen_e;

    // Number of compared pattern bits for a length code at data width w
    function automatic int plen_bits(input logic [1:0] sel, input int w);
        case (plen_e'(sel))
            PLEN_SHORT: return 7;
            PLEN_FULL:  return (w >= 20) ? 20 : 10;
            default:    return 10;
        endcase
    endfunction

endpackage

// File: rtl/wal_match.sv
// Compares the pattern at every candidate boundary of the two-word window.
module wal_match #(
    parameter int W = 20,
    localparam int WINW = 2 * W - 1
) (
    input  logic [WINW-1:0] win,
    input  logic [W-1:0]    pattern,
    input  logic [W-1:0]    mask,
    output logic [W-1:0]    hit
);

    for (genvar k = 0; k < W; k++) begin : g_off
        assign hit[k] = ~|((win[k +: W] ^ pattern) & mask);
    end

endmodule

// File: rtl/wal_pick.sv
// Lowest-index selection among matching offsets.
module wal_pick #(
    parameter int W = 20,
    localparam int OW = $clog2(W)
) (
    input  logic [W-1:0]  hit,
    output logic          found,
    output logic [OW-1:0] idx
);

    always_comb begin
        found = |hit;
        idx   = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (hit[k]) begin
                idx = OW'(k);
            end
        end
    end

endmodule

// File: rtl/wal_shift.sv
// Cuts one word out of the window at the given offset.
module wal_shift #(
    parameter int W = 20,
    localparam int OW = $clog2(W)
) (
    input  logic [2*W-1:0] win,
    input  logic [OW-1:0]  off,
    output logic [W-1:0]   word
);

    logic [2*W-1:0] shifted;

    always_comb begin
        shifted = win >> off;
        word    = shifted[W-1:0];
    end

endmodule

// File: rtl/word_aligner.sv
module word_aligner #(
    parameter int W = 20,
    parameter bit AUTO_LOCK = (W >= 20),
    localparam int OW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rx_word,
    input  logic         rx_valid,
    input  logic         align_en,
    input  logic [W-1:0] pat_value,
    input  logic [1:0]   pat_len_sel,
    output logic [W-1:0] word_out,
    output logic         word_valid,
    output logic         sync,
    output logic         pat_det
);

    import wal_pkg::*;

    typedef struct packed {
        logic [W-1:0]  prev;
        logic [OW-1:0] off;
        logic          sync;
        logic          armed;
        logic          en;
        logic [W-1:0]  out;
        logic          vout;
        logic          det;
    } st_t;

    st_t st_d, st_q;

    logic [2*W-1:0] win_full;
    logic [W-1:0]   mask;
    logic [W-1:0]   hit;
    logic           found;
    logic [OW-1:0]  found_idx;
    logic [W-1:0]   cut_word;
    logic [OW-1:0]  lock_off;
    logic           rise;
    logic           capture;

    assign win_full = {rx_word, st_q.prev};
    assign lock_off = st_q.off;

    // Comparison mask from the selected pattern length
    always_comb begin
        for (int i = 0; i < W; i++) begin
            mask[i] = (i < plen_bits(pat_len_sel, W));
        end
    end

    wal_match #(.W(W)) u_match (
        .win     (win_full[2*W-2:0]),
        .pattern (pat_value),
        .mask    (mask),
        .hit     (hit)
    );

    wal_pick #(.W(W)) u_pick (
        .hit   (hit),
        .found (found),
        .idx   (found_idx)
    );

    wal_shift #(.W(W)) u_shift (
        .win  (win_full),
        .off  (st_d.off),
        .word (cut_word)
    );

    always_comb begin
        st_d    = st_q;
        rise    = align_en & ~st_q.en;
        capture = st_q.armed & rx_valid & found & ~rise;

        st_d.en = align_en;

        if (capture) begin
            st_d.off   = found_idx;
            st_d.sync  = 1'b1;
            st_d.armed = 1'b0;
        end
        if (rise) begin
            st_d.sync  = 1'b0;
            st_d.armed = 1'b1;
        end

        st_d.vout = rx_valid;
        st_d.det  = rx_valid & st_d.sync & hit[st_d.off];
        if (rx_valid) begin
            st_d.prev = rx_word;
            st_d.out  = cut_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.armed <= AUTO_LOCK;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_out   = st_q.out;
    assign word_valid = st_q.vout;
    assign sync       = st_q.sync;
    assign pat_det    = st_q.det;

endmodule

// File: rtl/word_aligner_chk.sv
module word_aligner_chk #(
    parameter int W = 20,
    localparam int OW = $clog2(W)
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_valid,
    input logic          align_en,
    input logic          word_valid,
    input logic          sync,
    input logic          pat_det,
    input logic [OW-1:0] lock_off
);

    // R1: after a reset cycle the flags are low
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sync && !pat_det && !word_valid && lock_off == '0));

    // R3: an enable rising edge drops sync on the next clock
    a_r3_rise_clears: assert property (@(posedge clk) disable iff (rst)
        $rose(align_en) |=> !sync);

    // R4: a lock only follows a valid word
    a_r4_lock_on_valid: assert property (@(posedge clk) disable iff (rst)
        $rose(sync) |-> $past(rx_valid));

    // R6: while locked and not re-armed, offset and sync hold
    a_r6_hold_lock: assert property (@(posedge clk) disable iff (rst)
        (sync && !$rose(align_en)) |=> (sync && $stable(lock_off)));

    // R7: detect only while locked and on a delivered word
    a_r7_det_locked: assert property (@(posedge clk) disable iff (rst)
        pat_det |-> (sync && word_valid));

    // R9: output valid follows input valid by one clock
    a_r9_valid_follow: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> word_valid);

    a_r9_idle_follow: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !word_valid);

endmodule

bind word_aligner word_aligner_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .align_en   (align_en),
    .word_valid (word_valid),
    .sync       (sync),
    .pat_det    (pat_det),
    .lock_off   (lock_off)
);

// File: tb/word_aligner_test.sv
`timescale 1ns/1ps
module word_aligner_test;

    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] rx_word = '0;
    logic         rx_valid = 1'b0;
    logic         align_en = 1'b0;
    logic [W-1:0] pat_value = '0;
    logic [1:0]   pat_len_sel = 2'd0;
    logic [W-1:0] word_out;
    logic         word_valid;
    logic         sync;
    logic         pat_det;

    always #10 clk = ~clk;

    word_aligner #(.W(W)) uut (
        .clk(clk), .rst(rst), .rx_word(rx_word), .rx_valid(rx_valid),
        .align_en(align_en), .pat_value(pat_value), .pat_len_sel(pat_len_sel),
        .word_out(word_out), .word_valid(word_valid), .sync(sync), .pat_det(pat_det)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // Bench model state
    logic [W-1:0] m_prev, m_out;
    int m_off;
    bit m_sync, m_armed, m_en, m_vout, m_det;

    function automatic int len_of(logic [1:0] s);
        if (s == 2'd0) return 7;
        if (s == 2'd2) return (W >= 20) ? 20 : 10;
        return 10;
    endfunction

    function automatic bit match_at(logic [2*W-1:0] win, logic [W-1:0] pat, int len, int k);
        for (int i = 0; i < len; i++) begin
            if (win[k+i] !== pat[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic int find_low(logic [2*W-1:0] win, logic [W-1:0] pat, int len);
        for (int k = 0; k < W; k++) begin
            if (match_at(win, pat, len, k)) return k;
        end
        return -1;
    endfunction

    function automatic logic [2*W-1:0] place(logic [2*W-1:0] v, int k, logic [W-1:0] pat, int len);
        logic [2*W-1:0] r = v;
        for (int i = 0; i < len; i++) r[k+i] = pat[i];
        return r;
    endfunction

    task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_tick(logic [W-1:0] w, bit v, bit e);
        logic [2*W-1:0] win;
        int len, f;
        bit rise, cap;
        win  = {w, m_prev};
        len  = len_of(pat_len_sel);
        f    = find_low(win, pat_value, len);
        rise = e && !m_en;
        cap  = m_armed && v && (f >= 0) && !rise;
        if (cap) begin m_off = f; m_sync = 1'b1; m_armed = 1'b0; end
        if (rise) begin m_sync = 1'b0; m_armed = 1'b1; end
        m_vout = v;
        m_det  = v && m_sync && match_at(win, pat_value, len, m_off);
        if (v) begin
            m_out  = win[m_off +: W];
            m_prev = w;
        end
        m_en = e;
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic step(logic [W-1:0] w, bit v, bit e);
        rx_word  = w;
        rx_valid = v;
        align_en = e;
        @(posedge clk);
        model_tick(w, v, e);
        @(negedge clk);
        chk("R9", "word_valid", W'(word_valid), W'(m_vout));
        if (m_vout) chk("R4", "word_out", word_out, m_out);
        chk("R6", "sync", W'(sync), W'(m_sync));
        chk("R7", "pat_det", W'(pat_det), W'(m_det));
    endtask

    task automatic send_vec(logic [2*W-1:0] v, bit e);
        step('0, 1'b1, e);
        step(v[W-1:0], 1'b1, e);
        step(v[2*W-1:W], 1'b1, e);
    endtask

    task automatic do_reset();
        rst = 1'b1; rx_valid = 1'b0; align_en = 1'b0; rx_word = '0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_prev = '0; m_out = '0; m_off = 0; m_sync = 1'b0; m_armed = 1'b1;
        m_en = 1'b0; m_vout = 1'b0; m_det = 1'b0;
    endtask

    localparam logic [6:0]  P7  = 7'b1011001;
    localparam logic [9:0]  P10 = 10'h2F5;
    localparam logic [19:0] P20 = 20'hA5C3B;

    initial begin : main
        logic [2*W-1:0] v;
        bit en_r;
        void'($urandom(32'd2718));

        do_reset();
        // R1: reset state
        chk("R1", "sync", W'(sync), '0);
        chk("R1", "pat_det", W'(pat_det), '0);
        chk("R1", "word_valid", W'(word_valid), '0);
        chk("R1", "word_out", word_out, '0);

        // R2 / R8: automatic lock after reset; upper pattern bits are don't-care
        pat_len_sel = 2'd0;
        pat_value   = {13'h1ABC, P7};
        v = place('0, 5, W'(P7), 7);
        send_vec(v, 1'b0);
        chk("R2", "sync after auto lock", W'(sync), W'(1));
        chk("R2", "aligned word offset 5", word_out, v[5 +: W]);

        // R6: pattern at another offset does not move the boundary
        v = place('0, 9, W'(P7), 7);
        send_vec(v, 1'b0);
        chk("R6", "boundary held at 5", word_out, v[5 +: W]);

        // R3: rising edge clears sync
        step('0, 1'b0, 1'b1);
        chk("R3", "sync cleared by enable edge", W'(sync), '0);

        // R5: two matches, lowest offset wins
        v = place(place('0, 3, W'(P7), 7), 12, W'(P7), 7);
        send_vec(v, 1'b1);
        chk("R5", "sync", W'(sync), W'(1));
        chk("R5", "lowest offset 3", word_out, v[3 +: W]);

        // R6: enable held high does not re-arm
        v = place('0, 8, W'(P7), 7);
        send_vec(v, 1'b1);
        chk("R6", "held enable keeps offset 3", word_out, v[3 +: W]);
        chk("R7", "no detect off boundary", W'(pat_det), '0);

        // R7: detect pulse on the locked boundary
        v = place('0, 3, W'(P7), 7);
        send_vec(v, 1'b1);
        chk("R7", "detect pulse", W'(pat_det), W'(1));
        step('0, 1'b1, 1'b1);
        chk("R7", "detect one cycle", W'(pat_det), '0);

        // R8: 20-bit pattern
        step('0, 1'b0, 1'b0);
        pat_len_sel = 2'd2;
        pat_value   = P20;
        step('0, 1'b0, 1'b1);
        v = place('0, 7, P20, 20);
        send_vec(v, 1'b1);
        chk("R8", "20-bit lock", W'(sync), W'(1));
        chk("R8", "20-bit offset 7", word_out, v[7 +: W]);

        // R8: 10-bit pattern
        step('0, 1'b0, 1'b0);
        pat_len_sel = 2'd1;
        pat_value   = {10'h3FF, P10};
        step('0, 1'b0, 1'b1);
        v = place('0, 11, W'(P10), 10);
        send_vec(v, 1'b1);
        chk("R8", "10-bit offset 11", word_out, v[11 +: W]);

        // R10: invalid cycles between the two halves
        step('0, 1'b0, 1'b0);
        pat_len_sel = 2'd0;
        pat_value   = W'(P7);
        step('0, 1'b0, 1'b1);
        v = place('0, 16, W'(P7), 7);
        step('0, 1'b1, 1'b1);
        step(v[W-1:0], 1'b1, 1'b1);
        for (int i = 0; i < 3; i++) begin
            step(W'($urandom), 1'b0, 1'b1);
            chk("R10", "no output on idle", W'(word_valid), '0);
            chk("R10", "no lock on idle", W'(sync), '0);
        end
        step(v[2*W-1:W], 1'b1, 1'b1);
        chk("R10", "split pattern found", word_out, v[16 +: W]);

        // Random phase
        en_r = 1'b1;
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 3) begin
                en_r = ~en_r;
                if (!en_r) begin
                    pat_len_sel = 2'($urandom_range(0, 3));
                    pat_value   = W'($urandom);
                end
                step(W'($urandom), 1'b0, en_r);
            end else if (r < 12) begin
                v = {W'($urandom), W'($urandom)};
                v = place(v, $urandom_range(0, W - 1), pat_value, len_of(pat_len_sel));
                step(v[W-1:0], 1'b1, en_r);
                step(v[2*W-1:W], 1'b1, en_r);
            end else begin
                step(W'($urandom), ($urandom_range(0, 9) < 8), en_r);
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule